// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer and Result Port

This block is the digital side of an 8-bit successive-approximation converter that has a channel multiplexer in front of it. Before a conversion the host picks a channel. It puts the channel number on the address inputs and raises an address-latch strobe. It then pulses a start input. The block runs one acquire phase, in which the sample-and-hold and comparator auto-zero are both active. It then makes one bit decision per trial, MSB first. Each trial code is driven to an external DAC, and a single-bit comparator input decides whether that bit stays set.

`clk_i` runs at twice the converter clock, so one `clk_i` cycle is one half-period phase. A conversion takes one acquire phase plus two phases per bit, which is 17 phases (8.5 converter clocks) for 8 bits. The end-of-conversion flag stays low for the whole conversion. The finished code is copied into a separate output buffer on the same edge at which that flag rises. The buffer then holds until the next rise. The buffer reaches a shared bus through a three-state driver controlled by an output-enable input. A continuous mode starts a new conversion after each completion without a start pulse.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `eoc_o` is 1, `chan_o` is 0, `sample_o` is 0 and the result buffer holds 0.
- R2: A 1 on `start_i` at a rising edge of `clk_i` while `eoc_o` is 1 makes `eoc_o` go low after that edge. It stays low for exactly 1 + 2*DATA_W cycles (17 for 8 bits) and then returns to 1.
- R3: `sample_o` and `autozero_o` are 1 only in the first low cycle of `eoc_o` (the acquire phase) and are 0 at every other time.
- R4: Trials run MSB first, and each bit is presented for two cycles. While bit b is on trial, `trial_o` holds the bits already decided above b, bit b set to 1, and zeros below b. The bit is cleared if `cmp_lo_i` is 1 in the second cycle of its trial.
- R5: With a comparator that reports `cmp_lo_i = 1` exactly when the selected channel's input code is below `trial_o`, the result equals that input code, for every code from 0 to 255.
- R6: The result buffer changes only on the edge at which `eoc_o` rises. Between two such rises it stays unchanged, including during the next conversion.
- R7: When `oe_i` is 0, `data_io` is high-impedance. When `oe_i` is 1, `data_io` drives the result buffer.
- R8: A rising edge of `ale_i` (1 in this cycle, 0 in the previous one) captures `addr_i`. The captured address N becomes `chan_o` = N when the next conversion starts, and N selects channel N.
- R9: An `ale_i` edge during a conversion does not change `chan_o` before that conversion ends. The new address takes effect at the next acquire phase.
- R10: A `start_i` pulse during a conversion is ignored, and the conversion length is unchanged.
- R11: While `cont_i` is 1, `eoc_o` stays high for exactly one cycle after each completion before the next conversion begins. When `cont_i` is 0 the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase clock, twice the converter clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ale_i | input | 1 | Address-latch strobe, rising edge captures `addr_i` |
| addr_i | input | ADDR_W | Channel number to latch |
| start_i | input | 1 | Conversion start, active high |
| cont_i | input | 1 | Continuous-conversion enable |
| cmp_lo_i | input | 1 | Comparator: 1 when the input is below the DAC level |
| oe_i | input | 1 | Bus output enable |
| chan_o | output | ADDR_W | Channel select for the analog multiplexer |
| sample_o | output | 1 | Sample-and-hold acquire phase |
| autozero_o | output | 1 | Comparator auto-zero phase |
| trial_o | output | DATA_W | Trial code to the DAC |
| eoc_o | output | 1 | End of conversion, low while busy |
| data_io | inout | DATA_W | Three-state result bus |

## Verification
The assertions check four things on every cycle. Every low stretch of `eoc_o` lasts exactly 17 cycles. The acquire phase lines up with the falling edge of `eoc_o`. The first trial code is the MSB alone. The result buffer and the active channel stay stable away from their update points. Only the bench scenarios can show the rest, because each needs a modelled comparator or a chosen stimulus timing. That covers correct codes for all 256 inputs, the exact trial code sequence, channel selection and the deferred effect of a mid-conversion strobe. It also covers rejection of a mid-conversion start, the high-impedance bus and the one-cycle gap in continuous mode.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACQ   = 2'd1,
    ST_TRIAL = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sar_addr_latch.sv
module sar_addr_latch #(
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              go_i,
  output logic [ADDR_W-1:0] chan_o
);
  logic              ale_q;
  logic [ADDR_W-1:0] pend_q;
  logic [ADDR_W-1:0] chan_q;
  logic              ale_rise;

  assign ale_rise = ale_i & ~ale_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_q  <= 1'b0;
      pend_q <= '0;
      chan_q <= '0;
    end else begin
      ale_q <= ale_i;
      if (ale_rise) pend_q <= addr_i;
      // active channel only moves at the start of a sample phase
      if (go_i) chan_q <= pend_q;
    end
  end

  assign chan_o = chan_q;
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      cont_i,
  output logic                      go_o,
  output logic                      acq_o,
  output logic                      decide_o,
  output logic                      last_o,
  output logic [$clog2(DATA_W)-1:0] bit_idx_o,
  output logic                      eoc_o
);
  localparam int IDX_W = $clog2(DATA_W);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             half_q;

  assign go_o     = (state_q == ST_IDLE) && (start_i || cont_i);
  assign acq_o    = (state_q == ST_ACQ);
  assign decide_o = (state_q == ST_TRIAL) && half_q;
  assign last_o   = (idx_q == '0);
  assign bit_idx_o = idx_q;
  assign eoc_o    = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      half_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go_o) state_q <= ST_ACQ;
        ST_ACQ: begin
          state_q <= ST_TRIAL;
          idx_q   <= IDX_W'(DATA_W - 1);
          half_q  <= 1'b0;
        end
        ST_TRIAL: begin
          if (!half_q) begin
            half_q <= 1'b1;
          end else begin
            half_q <= 1'b0;
            if (idx_q == '0) state_q <= ST_IDLE;
            else             idx_q   <= idx_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_register.sv
module sar_register #(
  parameter int DATA_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      acq_i,
  input  logic                      decide_i,
  input  logic                      last_i,
  input  logic [$clog2(DATA_W)-1:0] bit_idx_i,
  input  logic                      cmp_lo_i,
  output logic [DATA_W-1:0]         trial_o,
  output logic [DATA_W-1:0]         result_o
);
  localparam logic [DATA_W-1:0] MSB = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] trial_q;
  logic [DATA_W-1:0] result_q;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] kept;

  assign mask = DATA_W'(1) << bit_idx_i;
  assign kept = cmp_lo_i ? (trial_q & ~mask) : trial_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trial_q  <= '0;
      result_q <= '0;
    end else begin
      if (clr_i) begin
        trial_q <= '0;
      end else if (acq_i) begin
        trial_q <= MSB;
      end else if (decide_i) begin
        trial_q <= last_i ? kept : (kept | (mask >> 1));
        // second buffer loads on the EOC rising edge only
        if (last_i) result_q <= kept;
      end
    end
  end

  assign trial_o  = trial_q;
  assign result_o = result_q;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int DATA_W = 8,
  parameter int CH_N   = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ale_i,
  input  logic [$clog2(CH_N)-1:0]     addr_i,
  input  logic                        start_i,
  input  logic                        cont_i,
  input  logic                        cmp_lo_i,
  input  logic                        oe_i,
  output logic [$clog2(CH_N)-1:0]     chan_o,
  output logic                        sample_o,
  output logic                        autozero_o,
  output logic [DATA_W-1:0]           trial_o,
  output logic                        eoc_o,
  inout  wire  [DATA_W-1:0]           data_io
);
  localparam int ADDR_W = $clog2(CH_N);
  localparam int IDX_W  = $clog2(DATA_W);

  logic             go;
  logic             acq;
  logic             decide;
  logic             last;
  logic [IDX_W-1:0] bit_idx;
  logic [DATA_W-1:0] result_q;

  sar_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ale_i  (ale_i),
    .addr_i (addr_i),
    .go_i   (go),
    .chan_o (chan_o)
  );

  sar_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cont_i    (cont_i),
    .go_o      (go),
    .acq_o     (acq),
    .decide_o  (decide),
    .last_o    (last),
    .bit_idx_o (bit_idx),
    .eoc_o     (eoc_o)
  );

  sar_register #(.DATA_W(DATA_W)) u_sar (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (go),
    .acq_i     (acq),
    .decide_i  (decide),
    .last_i    (last),
    .bit_idx_i (bit_idx),
    .cmp_lo_i  (cmp_lo_i),
    .trial_o   (trial_o),
    .result_o  (result_q)
  );

  assign sample_o   = acq;
  assign autozero_o = acq;
  assign data_io    = oe_i ? result_q : {DATA_W{1'bz}};
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              eoc_i,
  input logic              sample_i,
  input logic              autozero_i,
  input logic [DATA_W-1:0] trial_i,
  input logic [ADDR_W-1:0] chan_i,
  input logic [DATA_W-1:0] result_i
);
  localparam int CONV_PHASES = 1 + 2 * DATA_W;
  localparam int CNT_W = $clog2(CONV_PHASES + 1) + 1;
  localparam logic [DATA_W-1:0] MSB = {1'b1, {(DATA_W-1){1'b0}}};

  logic [CNT_W-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    low_cnt <= '0;
    else if (eoc_i) low_cnt <= '0;
    else            low_cnt <= low_cnt + 1'b1;
  end

  p_eoc_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoc_i) |-> (low_cnt == CNT_W'(CONV_PHASES)));

  p_low_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_i |-> (low_cnt < CNT_W'(CONV_PHASES)));

  p_sample_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eoc_i) |-> (sample_i && autozero_i));

  p_sample_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> $fell(eoc_i));

  p_msb_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sample_i) |-> (trial_i == MSB));

  p_result_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(eoc_i) |-> $stable(result_i));

  p_chan_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eoc_i && !sample_i) |-> $stable(chan_i));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .eoc_i      (eoc_o),
  .sample_i   (sample_o),
  .autozero_i (autozero_o),
  .trial_i    (trial_o),
  .chan_i     (chan_o),
  .result_i   (result_q)
);

// File: tb/sar_adc_ctrl_tb_top.sv
module sar_adc_ctrl_tb_top;
  localparam int DW = 8;
  localparam int CN = 8;
  localparam int AW = 3;
  localparam int PHASES = 1 + 2 * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ale = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          start = 1'b0;
  logic          cont = 1'b0;
  logic          oe = 1'b1;
  logic          cmp_lo;
  logic [AW-1:0] chan;
  logic          sample;
  logic          autozero;
  logic [DW-1:0] trial;
  logic          eoc;
  wire  [DW-1:0] bus_w;
  logic [DW-1:0] tgt [CN];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  for (genvar g = 0; g < DW; g++) begin : g_pu
    pullup (bus_w[g]);
  end

  // behavioural comparator: input below DAC level
  assign cmp_lo = tgt[chan] < trial;

  sar_adc_ctrl #(.DATA_W(DW), .CH_N(CN)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ale_i      (ale),
    .addr_i     (addr),
    .start_i    (start),
    .cont_i     (cont),
    .cmp_lo_i   (cmp_lo),
    .oe_i       (oe),
    .chan_o     (chan),
    .sample_o   (sample),
    .autozero_o (autozero),
    .trial_o    (trial),
    .eoc_o      (eoc),
    .data_io    (bus_w)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic latch_addr(input int a);
    @(negedge clk); ale = 1'b1; addr = AW'(a);
    @(negedge clk); ale = 1'b0;
  endtask

  // runs one conversion; ch is the channel expected active
  task automatic run_conv(input int ch, input int v, input bit mid, input int mid_addr);
    int k;
    int b;
    int exp_t;
    int prev;
    tgt[ch] = DW'(v);
    @(negedge clk);
    prev = int'(bus_w);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    k = 1;
    while (eoc === 1'b0 && k < 100) begin
      if (k == 1) begin
        chk(sample === 1'b1 && autozero === 1'b1, "R3 acquire", int'(sample), 1);
      end else begin
        chk(sample === 1'b0 && autozero === 1'b0, "R3 no sample", int'(sample), 0);
        b = DW - 1 - (k - 2) / 2;
        exp_t = ((v >> (b + 1)) << (b + 1)) | (1 << b);
        chk(int'(trial) == exp_t, "R4 trial code", int'(trial), exp_t);
      end
      chk(int'(bus_w) == prev, "R6 hold", int'(bus_w), prev);
      chk(int'(chan) == ch, "R9 chan", int'(chan), ch);
      if (mid) begin
        if (k == 5) begin ale = 1'b1; addr = AW'(mid_addr); end
        if (k == 6) ale = 1'b0;
        if (k == 7) start = 1'b1;  // R10 stray start
        if (k == 8) start = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    chk(k - 1 == PHASES, "R2 eoc low length", k - 1, PHASES);
    chk(int'(bus_w) == v, "R5 result", int'(bus_w), v);
  endtask

  initial begin
    int lows;
    int highs;
    for (int i = 0; i < CN; i++) tgt[i] = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(eoc === 1'b1, "R1 eoc in reset", int'(eoc), 1);
    chk(int'(bus_w) == 0, "R1 result in reset", int'(bus_w), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(eoc === 1'b1 && sample === 1'b0, "R1 eoc idle", int'(eoc), 1);
    chk(int'(chan) == 0, "R1 chan", int'(chan), 0);
    chk(int'(bus_w) == 0, "R1 result", int'(bus_w), 0);

    // R5 R8: all codes, rotating channel
    for (int v = 0; v < 256; v++) begin
      latch_addr(v % CN);
      run_conv(v % CN, v, 1'b0, 0);
    end

    // R6: result holds after completion despite input change
    latch_addr(2);
    run_conv(2, 8'h3C, 1'b0, 0);
    tgt[2] = 8'hC3;
    repeat (5) @(negedge clk);
    chk(int'(bus_w) == 8'h3C, "R6 idle hold", int'(bus_w), 8'h3C);
    chk(eoc === 1'b1, "R10 stays idle", int'(eoc), 1);

    // R7: tri-state, pulled high when disabled
    latch_addr(5);
    run_conv(5, 8'h00, 1'b0, 0);
    oe = 1'b0; #1;
    chk(int'(bus_w) == 8'hFF, "R7 hiz", int'(bus_w), 8'hFF);
    oe = 1'b1; #1;
    chk(int'(bus_w) == 8'h00, "R7 drive", int'(bus_w), 8'h00);
    run_conv(5, 8'h5A, 1'b0, 0);
    oe = 1'b0; #1;
    chk(int'(bus_w) == 8'hFF, "R7 hiz 2", int'(bus_w), 8'hFF);
    oe = 1'b1; #1;
    chk(int'(bus_w) == 8'h5A, "R7 drive 2", int'(bus_w), 8'h5A);

    // R9 R10: strobe and start during conversion
    latch_addr(1);
    tgt[6] = 8'h99;
    run_conv(1, 8'h77, 1'b1, 6);
    chk(eoc === 1'b1, "R10 no restart", int'(eoc), 1);
    run_conv(6, 8'h99, 1'b0, 0);
    chk(int'(chan) == 6, "R8 deferred chan", int'(chan), 6);

    // R11: continuous mode
    latch_addr(3);
    tgt[3] = 8'hA5;
    @(negedge clk);
    cont = 1'b1;
    @(negedge clk);
    for (int rep = 0; rep < 3; rep++) begin
      lows = 0;
      while (eoc === 1'b0 && lows < 100) begin
        lows++;
        @(negedge clk);
      end
      chk(lows == PHASES, "R11 conv length", lows, PHASES);
      chk(int'(bus_w) == 8'hA5, "R11 result", int'(bus_w), 8'hA5);
      if (rep == 2) cont = 1'b0;
      highs = 0;
      while (eoc === 1'b1 && highs < 6) begin
        highs++;
        @(negedge clk);
      end
      if (rep < 2) chk(highs == 1, "R11 gap", highs, 1);
      else         chk(highs == 6, "R11 stop", highs, 6);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule